// File: doc/BRIEF.md
# E4M3 Byte to Single-Precision Widener

This block takes an 8-bit floating-point byte in the finite-only E4M3 layout and produces the IEEE single-precision bit pattern that stands for the same value. A producer presents the byte together with a valid strobe. One clock later the 32-bit word appears on a register with its own valid flag. There is no backpressure, so a new byte may be accepted on every cycle. The conversion uses only integer and bit operations.

The source format has a sign bit in bit 7, a 4-bit exponent field in bits 6:3 with a bias of 7, and a 3-bit fraction in bits 2:0. It has no infinity. The only NaN magnitude is the all-ones pattern in bits 6:0, so an exponent field of 15 with any other fraction is an ordinary finite value. Subnormal bytes are renormalized. A leading-zero count on the fraction sets the shift, and the same count is taken off the rebiased exponent.

Top module: `e4m3_widen`

## Requirements
- R1: Output bit 31 always equals input bit 7 of the accepted byte, for every code including zero and NaN.
- R2: For a byte whose exponent field (bits 6:3) is nonzero and which is not NaN, output bits 30:23 equal that field plus 120. Output bits 22:20 equal input bits 2:0, and output bits 19:0 are zero.
- R3: For a byte whose exponent field is zero and whose fraction f (bits 2:0) is nonzero, let p be the index of the highest set bit of f. The output exponent is 118+p, and the output fraction holds the bits of f below p, left-aligned at bit 22. Example: 0x01 gives 0x3B000000.
- R4: Bytes 0x7F and 0xFF (bits 6:0 all ones) give 0x7FF00000 and 0xFFF00000 respectively.
- R5: Bytes 0x00 and 0x80 give 0x00000000 and 0x80000000 respectively.
- R6: An exponent field of 15 with fraction below 7 is finite and follows R2. Example: 0x7E gives 0x43E00000 and 0xF8 gives 0xC3800000.
- R7: The output valid is high in exactly the cycle after a cycle with input valid high, and the word shown then is the conversion of the byte accepted in that cycle, also for back-to-back inputs.
- R8: While input valid is low, the output word keeps its last value whatever the input byte does.
- R9: A synchronous active-high reset clears both the output word and the output valid to zero, even if input valid is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input byte is valid this cycle |
| inByte | input | 8 | E4M3 source byte |
| outValid | output | 1 | Output word valid (one cycle after inValid) |
| outWord | output | 32 | Single-precision bit pattern |

## Verification
The hardest cases to reach from the ports are at the edges of the subnormal range, where the shift changes from one to three positions, and the codes next to the single NaN. There, 0x7E and 0xFE must stay finite while 0x7F and 0xFF must not. The stimulus sends directed bytes for each of these edges and then sweeps all 256 codes back to back, so every shift amount and both signs pass through the path with no idle gap. Stretches with valid low and a changing byte confirm that the held word does not move.

// File: rtl/widen_pkg.sv
package widen_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // load a newly converted word
    logic clear;     // force the output register to zero
  } ctrlStrobe_t;
endpackage

// File: rtl/widen_lzc.sv
module widen_lzc #(
  parameter int unsigned W    = 3,
  localparam int unsigned LZW = $clog2(W + 1)
) (
  input  logic [W-1:0]   vec,
  output logic [LZW-1:0] count
);
  logic found;
  always_comb begin
    count = LZW'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec[i]) begin
        count = LZW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/widen_ctrl.sv
module widen_ctrl
  import widen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.clear   = rst;
    strobe.capture = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/widen_datapath.sv
module widen_datapath
  import widen_pkg::*;
#(
  parameter int unsigned SRC_EXP_W = 4,
  parameter int unsigned SRC_MAN_W = 3,
  parameter int unsigned SRC_BIAS  = 7,
  parameter int unsigned DST_EXP_W = 8,
  parameter int unsigned DST_MAN_W = 23,
  parameter int unsigned DST_BIAS  = 127,
  localparam int unsigned SRC_W    = 1 + SRC_EXP_W + SRC_MAN_W,
  localparam int unsigned DST_W    = 1 + DST_EXP_W + DST_MAN_W
) (
  input  logic             clk,
  input  ctrlStrobe_t      strobe,
  input  logic [SRC_W-1:0] inByte,
  output logic [DST_W-1:0] outWord
);
  localparam int unsigned LZW     = $clog2(SRC_MAN_W + 1);
  localparam int unsigned PAD_W   = DST_MAN_W - SRC_MAN_W;
  localparam int unsigned WIDE_W  = 2 * SRC_MAN_W + 1;
  localparam logic [DST_EXP_W-1:0] GAP = DST_EXP_W'(DST_BIAS - SRC_BIAS);

  logic                 srcSign;
  logic [SRC_EXP_W-1:0] srcExp;
  logic [SRC_MAN_W-1:0] srcMan;
  logic                 isZero, isNan, isSub;
  logic [LZW-1:0]       leadZeros;
  logic [LZW:0]         shiftAmt;
  logic [WIDE_W-1:0]    shifted;
  logic [SRC_MAN_W-1:0] normMan;
  logic [DST_EXP_W-1:0] dstExp;
  logic [SRC_MAN_W-1:0] dstManTop;
  logic [DST_W-1:0]     nextWord;

  assign srcSign = inByte[SRC_W-1];
  assign srcExp  = inByte[SRC_W-2 -: SRC_EXP_W];
  assign srcMan  = inByte[SRC_MAN_W-1:0];

  assign isZero = (srcExp == '0) && (srcMan == '0);
  assign isNan  = &inByte[SRC_W-2:0];
  assign isSub  = (srcExp == '0) && (srcMan != '0);

  widen_lzc #(.W(SRC_MAN_W)) u_lzc (
    .vec   (srcMan),
    .count (leadZeros)
  );

  // leading one must leave the fraction: one position past the zero count
  assign shiftAmt = {1'b0, leadZeros} + (LZW+1)'(1);
  assign shifted  = WIDE_W'(srcMan) << shiftAmt;
  assign normMan  = shifted[SRC_MAN_W-1:0];

  always_comb begin
    if (isNan) begin
      dstExp    = '1;
      dstManTop = '1;
    end else if (isZero) begin
      dstExp    = '0;
      dstManTop = '0;
    end else if (isSub) begin
      dstExp    = GAP + DST_EXP_W'(1) - DST_EXP_W'(shiftAmt);
      dstManTop = normMan;
    end else begin
      dstExp    = DST_EXP_W'(srcExp) + GAP;
      dstManTop = srcMan;
    end
    nextWord = {srcSign, dstExp, dstManTop, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        outWord <= '0;
    else if (strobe.capture) outWord <= nextWord;
  end
endmodule

// File: rtl/e4m3_widen.sv
module e4m3_widen
  import widen_pkg::*;
#(
  parameter int unsigned SRC_EXP_W = 4,
  parameter int unsigned SRC_MAN_W = 3,
  parameter int unsigned SRC_BIAS  = 7,
  parameter int unsigned DST_EXP_W = 8,
  parameter int unsigned DST_MAN_W = 23,
  parameter int unsigned DST_BIAS  = 127,
  localparam int unsigned SRC_W    = 1 + SRC_EXP_W + SRC_MAN_W,
  localparam int unsigned DST_W    = 1 + DST_EXP_W + DST_MAN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [SRC_W-1:0] inByte,
  output logic             outValid,
  output logic [DST_W-1:0] outWord
);
  ctrlStrobe_t strobe;

  widen_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  widen_datapath #(
    .SRC_EXP_W (SRC_EXP_W),
    .SRC_MAN_W (SRC_MAN_W),
    .SRC_BIAS  (SRC_BIAS),
    .DST_EXP_W (DST_EXP_W),
    .DST_MAN_W (DST_MAN_W),
    .DST_BIAS  (DST_BIAS)
  ) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .inByte  (inByte),
    .outWord (outWord)
  );
endmodule

// File: rtl/widen_checks.sv
module widen_checks (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [7:0]  inByte,
  input logic        outValid,
  input logic [31:0] outWord
);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_drops_r7: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outWord));
  p_sign_pass_r1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outWord[31] == $past(inByte[7]));
  p_nan_code_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inByte[6:0] == 7'h7F) |=> outWord[30:0] == 31'h7FF00000);
  p_signed_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && inByte[6:0] == 7'h00) |=> outWord[30:0] == 31'h0);
  p_normal_exp_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inByte[6:3] != 4'h0 && inByte[6:0] != 7'h7F)
      |=> outWord[30:23] == 8'($past(inByte[6:3])) + 8'd120);
  p_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> outWord[19:0] == 20'h0);
endmodule

bind e4m3_widen widen_checks u_checks (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inByte   (inByte),
  .outValid (outValid),
  .outWord  (outWord)
);

// File: tb/e4m3_widen_tb.sv
`timescale 1ns/1ps
module e4m3_widen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [7:0]  inByte;
  logic        outValid;
  logic [31:0] outWord;
  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  e4m3_widen u_dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inByte   (inByte),
    .outValid (outValid),
    .outWord  (outWord)
  );

  // expected word worked out from the requirement text
  function automatic logic [31:0] expect_word(input logic [7:0] b);
    logic       s;
    logic [3:0] e;
    logic [2:0] f;
    int         p;
    logic [22:0] man;
    s = b[7]; e = b[6:3]; f = b[2:0];
    if (b[6:0] == 7'h7F) return {s, 31'h7FF00000};
    if (b[6:0] == 7'h00) return {s, 31'h0};
    if (e != 4'h0) return {s, 8'(e) + 8'd120, f, 20'h0};
    p = f[2] ? 2 : (f[1] ? 1 : 0);
    man = 23'(f ^ (3'(1) << p)) << (23 - p);
    return {s, 8'(118 + p), man};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input string req, input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1; inByte = b;
    @(negedge clk);
    inValid = 1'b0;
    check(req, {31'h0, outValid}, 32'h1);
    check(req, outWord, expect_word(b));
  endtask

  task automatic t_reset;
    rst = 1'b1; inValid = 1'b1; inByte = 8'h55;
    repeat (3) @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    check("R9 valid after reset", {31'h0, outValid}, 32'h0);
    check("R9 word after reset", outWord, 32'h0);
  endtask

  task automatic t_zero;
    send("R5 +0", 8'h00);
    check("R5 +0 literal", outWord, 32'h00000000);
    send("R5 -0", 8'h80);
    check("R5 -0 literal", outWord, 32'h80000000);
  endtask

  task automatic t_normal;
    send("R2 one", 8'h38);
    check("R2 one literal", outWord, 32'h3F800000);
    send("R2 min normal", 8'h08);
    send("R1 negative normal", 8'hC5);
  endtask

  task automatic t_subnormal;
    send("R3 smallest", 8'h01);
    check("R3 0x01 literal", outWord, 32'h3B000000);
    send("R3 0x03", 8'h03);
    send("R3 0x07", 8'h07);
    send("R3 negative 0x84", 8'h84);
  endtask

  task automatic t_nan;
    send("R4 +nan", 8'h7F);
    check("R4 +nan literal", outWord, 32'h7FF00000);
    send("R4 -nan", 8'hFF);
    check("R4 -nan literal", outWord, 32'hFFF00000);
  endtask

  task automatic t_top_exp;
    send("R6 max finite", 8'h7E);
    check("R6 0x7E literal", outWord, 32'h43E00000);
    send("R6 0xF8", 8'hF8);
    check("R6 0xF8 literal", outWord, 32'hC3800000);
  endtask

  task automatic t_hold;
    logic [31:0] held;
    send("R8 setup", 8'h4A);
    held = outWord;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      inByte = 8'(k * 37 + 1);
      @(negedge clk);
      check("R8 held word", outWord, held);
      check("R7 idle valid low", {31'h0, outValid}, 32'h0);
    end
  endtask

  task automatic t_sweep;
    @(negedge clk);
    inValid = 1'b1; inByte = 8'h00;
    for (int c = 1; c <= 256; c++) begin
      @(negedge clk);
      check("R7 sweep valid", {31'h0, outValid}, 32'h1);
      check("R7 sweep word", outWord, expect_word(8'(c - 1)));
      inByte = 8'(c);
      if (c == 256) inValid = 1'b0;
    end
    @(negedge clk);
    check("R7 valid drops", {31'h0, outValid}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_normal();
    t_subnormal();
    t_nan();
    t_top_exp();
    t_hold();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule